// File: doc/BRIEF.md
# Reset Release and Clock-Ready Sequencer

This block takes the raw reset requests of a microcontroller-style system and turns them into a timed release of the system reset. Eight request sources are handled: power-on, brown-out, external pin, watchdog, software, illegal opcode, uninitialized register and trap conflict. The chosen request sets how many reference ticks the system reset stays asserted. The chosen clock class sets whether an oscillator start-up count, a PLL lock wait, both, or neither must finish before the clock counts as ready. These clock waits start at the same moment as the reset delay and run alongside it.

Execution is allowed once the reset is released and the clock is ready. For power-on and brown-out starts on a crystal or PLL source, the clock-monitor enable follows the release only after a further tick delay. The block also latches which request started the sequence and which clock-source code the system should boot from. All delays are parameters counted in ticks of a free-running reference strobe. The oscillator start-up wait counts oscillator-edge strobes instead.

Top module: `rstSequencer`

## Requirements
- R1: A power-on request (causeReq bit 0) keeps sysRstN low for TPOR + startup + TRST reference ticks. sysRstN rises at the clock edge that samples the last of those ticks.
- R2: A brown-out request (bit 1) keeps sysRstN low for startup + TRST ticks, with no power-on delay.
- R3: Pin (bit 2), watchdog (bit 3), software (bit 4), illegal opcode (bit 5), uninitialized register (bit 6) and trap conflict (bit 7) requests keep sysRstN low for TRST ticks only, for any clock class.
- R4: The startup delay is TSTART_ON ticks when regulatorOn is 1 and TSTART_OFF ticks when it is 0. The value is sampled in the cycle the request arrives.
- R5: clkClass is sampled with the request. 2'b00 means internal or external clock without PLL, 2'b01 means the same with PLL, 2'b10 means crystal, and 2'b11 means crystal with PLL. Bit 1 requires OST_EDGES oscEdge strobes and bit 0 requires TLOCK ticks. clkReady rises once every required wait is done, or one cycle after the request when none is required.
- R6: runEnable is high exactly when sysRstN and clkReady are both high.
- R7: For a power-on or brown-out request with clkClass other than 2'b00, monitorEnable rises TFSCM ticks after the release. The ticks are counted from those after the release edge. In every other case it rises on the same edge as sysRstN.
- R8: When several request bits are set together, the lowest-numbered bit wins. causeLatched then holds only that bit, one cycle after the request.
- R9: bootSource takes cfgSource when switchEnable is 0 or the winning request is power-on or brown-out. Otherwise it takes curSource. It changes only when a request arrives.
- R10: A request arriving mid-sequence lowers sysRstN, clkReady, runEnable and monitorEnable and restarts every wait from its start.
- R11: While rstN is low, and afterwards until the first request, sysRstN, clkReady, runEnable and monitorEnable are 0 and causeLatched is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset of the block itself |
| tick | input | 1 | One-cycle reference-tick strobe |
| oscEdge | input | 1 | One-cycle strobe per oscillator period, already synchronized |
| causeReq | input | 8 | Reset request bits, bit 0 power-on up to bit 7 trap conflict |
| regulatorOn | input | 1 | Selects the short startup delay |
| clkClass | input | 2 | Clock-source class: bit 1 crystal, bit 0 PLL |
| switchEnable | input | 1 | Clock switching allowed |
| cfgSource | input | 3 | Configured clock-source code |
| curSource | input | 3 | Currently active clock-source code |
| sysRstN | output | 1 | Active-low system reset |
| clkReady | output | 1 | System clock may be passed on |
| runEnable | output | 1 | Execution may start |
| monitorEnable | output | 1 | Clock-monitor enable |
| causeLatched | output | 8 | One-hot record of the winning request |
| bootSource | output | 3 | Clock-source code to boot from |

## Verification
A request sampled at edge k updates causeLatched and bootSource at edge k, so they are visible one cycle after the request. With no clock wait, clkReady is also high after edge k. The release and the end of each wait occur at the edge that samples the final required tick or oscillator strobe. monitorEnable follows on the edge that samples the TFSCM-th tick after the release. A behavioural model in the bench keeps remaining-count integers, updates them on the same edges, and compares every output at the following falling edge. Each output is therefore checked in the exact cycle it is due.

// File: rtl/rstSeqPkg.sv
package rstSeqPkg;
  // bit positions of the request vector; priority is lowest index first
  localparam int CAUSE_N = 8;
  localparam int C_POWER = 0;
  localparam int C_BROWN = 1;

  typedef struct packed {
    logic restart;   // a request was accepted this cycle
    logic needOst;   // crystal-class source: count oscillator edges
    logic needLock;  // PLL-class source: count lock ticks
    logic needMon;   // monitor enable is delayed after release
  } seqStrobes_t;
endpackage

// File: rtl/rstSeqCtrl.sv
module rstSeqCtrl #(
  parameter int TPOR = 10,
  parameter int TSTART_ON = 20,
  parameter int TSTART_OFF = 64000,
  parameter int TRST = 20,
  parameter int CNT_W = 17
) (
  input  logic clk,
  input  logic rstN,
  input  logic [rstSeqPkg::CAUSE_N-1:0] causeReq,
  input  logic regulatorOn,
  input  logic [1:0] clkClass,
  input  logic switchEnable,
  input  logic [2:0] cfgSource,
  input  logic [2:0] curSource,
  output rstSeqPkg::seqStrobes_t strobes,
  output logic [CNT_W-1:0] rstTotal,
  output logic [rstSeqPkg::CAUSE_N-1:0] causeLatched,
  output logic [2:0] bootSource
);
  import rstSeqPkg::*;

  localparam logic [CNT_W-1:0] PorTicks = CNT_W'(TPOR);
  localparam logic [CNT_W-1:0] StartOnTicks = CNT_W'(TSTART_ON);
  localparam logic [CNT_W-1:0] StartOffTicks = CNT_W'(TSTART_OFF);
  localparam logic [CNT_W-1:0] RstTicks = CNT_W'(TRST);

  logic [CAUSE_N-1:0] winner;
  logic [CNT_W-1:0] startTicks;
  logic longChain;

  // isolate lowest set request bit
  assign winner = causeReq & (~causeReq + CAUSE_N'(1));
  assign longChain = winner[C_POWER] | winner[C_BROWN];
  assign startTicks = regulatorOn ? StartOnTicks : StartOffTicks;

  always_comb begin
    if (winner[C_POWER]) rstTotal = PorTicks + startTicks + RstTicks;
    else if (winner[C_BROWN]) rstTotal = startTicks + RstTicks;
    else rstTotal = RstTicks;
  end

  always_comb begin
    strobes.restart = |causeReq;
    strobes.needOst = clkClass[1];
    strobes.needLock = clkClass[0];
    strobes.needMon = longChain && (clkClass != 2'b00);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeLatched <= '0;
      bootSource <= '0;
    end else if (strobes.restart) begin
      causeLatched <= winner;
      bootSource <= (!switchEnable || longChain) ? cfgSource : curSource;
    end
  end

  a_r8_onehot_latch: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(causeLatched));
  a_r8_power_wins: assert property (@(posedge clk) disable iff (!rstN)
    causeReq[C_POWER] |=> causeLatched[C_POWER]);
  a_r9_boot_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.restart |=> $stable(bootSource));
endmodule

// File: rtl/rstSeqTimers.sv
module rstSeqTimers #(
  parameter int TLOCK = 20,
  parameter int TFSCM = 100,
  parameter int OST_EDGES = 1024,
  parameter int CNT_W = 17
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic oscEdge,
  input  rstSeqPkg::seqStrobes_t strobes,
  input  logic [CNT_W-1:0] rstTotal,
  output logic released,
  output logic clkReady,
  output logic monOn
);
  localparam int OST_W = $clog2(OST_EDGES + 1);
  localparam int LOCK_W = $clog2(TLOCK + 1);
  localparam int MON_W = $clog2(TFSCM + 1);

  logic [CNT_W-1:0] rstCnt;
  logic [OST_W-1:0] ostCnt;
  logic [LOCK_W-1:0] lockCnt;
  logic [MON_W-1:0] monCnt;
  logic armed, monDelayed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
      ostCnt <= '0;
      lockCnt <= '0;
      monCnt <= '0;
      armed <= 1'b0;
      released <= 1'b0;
      monOn <= 1'b0;
      monDelayed <= 1'b0;
    end else if (strobes.restart) begin
      rstCnt <= rstTotal;
      ostCnt <= strobes.needOst ? OST_W'(OST_EDGES) : '0;
      lockCnt <= strobes.needLock ? LOCK_W'(TLOCK) : '0;
      monCnt <= MON_W'(TFSCM);
      armed <= 1'b1;
      released <= 1'b0;
      monOn <= 1'b0;
      monDelayed <= strobes.needMon;
    end else begin
      // reset delay chain, counted as one total
      if (armed && !released && tick) begin
        rstCnt <= rstCnt - CNT_W'(1);
        if (rstCnt == CNT_W'(1)) begin
          released <= 1'b1;
          if (!monDelayed) monOn <= 1'b1;
        end
      end
      // monitor delay starts after release
      if (released && !monOn && tick) begin
        monCnt <= monCnt - MON_W'(1);
        if (monCnt == MON_W'(1)) monOn <= 1'b1;
      end
      // clock waits run alongside the reset delay
      if (ostCnt != '0 && oscEdge) ostCnt <= ostCnt - OST_W'(1);
      if (lockCnt != '0 && tick) lockCnt <= lockCnt - LOCK_W'(1);
    end
  end

  assign clkReady = armed && (ostCnt == '0) && (lockCnt == '0);

  a_r1_release_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(released) |-> $past(tick));
  a_r7_monitor_after_release: assert property (@(posedge clk) disable iff (!rstN)
    monOn |-> released);
  a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    (clkReady && !strobes.restart) |=> clkReady);
  a_r10_restart_drops: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (!released && !monOn));
endmodule

// File: rtl/rstSequencer.sv
module rstSequencer #(
  parameter int TPOR = 10,
  parameter int TSTART_ON = 20,
  parameter int TSTART_OFF = 64000,
  parameter int TRST = 20,
  parameter int TLOCK = 20,
  parameter int TFSCM = 100,
  parameter int OST_EDGES = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic oscEdge,
  input  logic [7:0] causeReq,
  input  logic regulatorOn,
  input  logic [1:0] clkClass,
  input  logic switchEnable,
  input  logic [2:0] cfgSource,
  input  logic [2:0] curSource,
  output logic sysRstN,
  output logic clkReady,
  output logic runEnable,
  output logic monitorEnable,
  output logic [7:0] causeLatched,
  output logic [2:0] bootSource
);
  localparam int START_MAX = (TSTART_ON > TSTART_OFF) ? TSTART_ON : TSTART_OFF;
  localparam int CNT_W = $clog2(TPOR + START_MAX + TRST + 1);

  rstSeqPkg::seqStrobes_t strobes;
  logic [CNT_W-1:0] rstTotal;
  logic released;

  rstSeqCtrl #(.TPOR(TPOR), .TSTART_ON(TSTART_ON), .TSTART_OFF(TSTART_OFF),
               .TRST(TRST), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .causeReq(causeReq), .regulatorOn(regulatorOn),
    .clkClass(clkClass), .switchEnable(switchEnable), .cfgSource(cfgSource),
    .curSource(curSource), .strobes(strobes), .rstTotal(rstTotal),
    .causeLatched(causeLatched), .bootSource(bootSource));

  rstSeqTimers #(.TLOCK(TLOCK), .TFSCM(TFSCM), .OST_EDGES(OST_EDGES),
                 .CNT_W(CNT_W)) u_timers (
    .clk(clk), .rstN(rstN), .tick(tick), .oscEdge(oscEdge), .strobes(strobes),
    .rstTotal(rstTotal), .released(released), .clkReady(clkReady),
    .monOn(monitorEnable));

  assign sysRstN = released;
  assign runEnable = released & clkReady;
endmodule

// File: tb/rstSequencer_bench.sv
module rstSequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P_POR = 3, P_SON = 4, P_SOFF = 9, P_RST = 5;
  localparam int P_LOCK = 6, P_FSCM = 7, P_OST = 8;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, oscEdge = 1'b0;
  logic [7:0] causeReq = '0;
  logic regulatorOn = 1'b1, switchEnable = 1'b1;
  logic [1:0] clkClass = 2'b00;
  logic [2:0] cfgSource = 3'd5, curSource = 3'd2;
  logic sysRstN, clkReady, runEnable, monitorEnable;
  logic [7:0] causeLatched;
  logic [2:0] bootSource;

  int checks = 0, fails = 0, cyc = 0;
  string relTag = "R11";
  bit started = 0;

  // reference model state
  int mRst, mOst, mLock, mMon;
  bit mArmed, mRel, mMonOn, mNeedMon;
  logic [7:0] mCause;
  logic [2:0] mBoot;

  rstSequencer #(.TPOR(P_POR), .TSTART_ON(P_SON), .TSTART_OFF(P_SOFF), .TRST(P_RST),
                 .TLOCK(P_LOCK), .TFSCM(P_FSCM), .OST_EDGES(P_OST)) u_rstSequencer (
    .clk(clk), .rstN(rstN), .tick(tick), .oscEdge(oscEdge), .causeReq(causeReq),
    .regulatorOn(regulatorOn), .clkClass(clkClass), .switchEnable(switchEnable),
    .cfgSource(cfgSource), .curSource(curSource), .sysRstN(sysRstN),
    .clkReady(clkReady), .runEnable(runEnable), .monitorEnable(monitorEnable),
    .causeLatched(causeLatched), .bootSource(bootSource));

  always #(CLK_PERIOD/2) clk = ~clk;

  // strobe patterns: tick every 2nd cycle, oscillator edge every 3rd
  always @(negedge clk) begin
    cyc++;
    tick = (cyc % 2 == 0);
    oscEdge = (cyc % 3 == 1);
  end

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      mArmed = 0; mRel = 0; mMonOn = 0; mNeedMon = 0;
      mRst = 0; mOst = 0; mLock = 0; mMon = 0; mCause = '0; mBoot = '0;
    end else if (causeReq != 0) begin
      int win;
      int startLen;
      win = -1;
      for (int i = 7; i >= 0; i--) if (causeReq[i]) win = i;
      startLen = regulatorOn ? P_SON : P_SOFF;
      mCause = '0; mCause[win] = 1'b1;
      if (win == 0) mRst = P_POR + startLen + P_RST;
      else if (win == 1) mRst = startLen + P_RST;
      else mRst = P_RST;
      mBoot = (!switchEnable || win <= 1) ? cfgSource : curSource;
      mOst = clkClass[1] ? P_OST : 0;
      mLock = clkClass[0] ? P_LOCK : 0;
      mNeedMon = (win <= 1) && (clkClass != 2'b00);
      mMon = P_FSCM; mArmed = 1; mRel = 0; mMonOn = 0;
    end else begin
      bit wasRel;
      wasRel = mRel;
      if (mArmed && !mRel && tick) begin
        mRst--;
        if (mRst == 0) begin mRel = 1; if (!mNeedMon) mMonOn = 1; end
      end
      if (wasRel && !mMonOn && tick) begin
        mMon--;
        if (mMon == 0) mMonOn = 1;
      end
      if (mOst > 0 && oscEdge) mOst--;
      if (mLock > 0 && tick) mLock--;
    end
  end

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      bit mReady;
      mReady = mArmed && mOst == 0 && mLock == 0;
      cmp(relTag, "sysRstN", sysRstN, mRel);
      cmp("R5", "clkReady", clkReady, mReady);
      cmp("R6", "runEnable", runEnable, mRel && mReady);
      cmp("R7", "monitorEnable", monitorEnable, mMonOn);
      cmp("R8", "causeLatched", causeLatched, mCause);
      cmp("R9", "bootSource", bootSource, mBoot);
    end
  end

  task automatic request(logic [7:0] req, string tag);
    @(negedge clk);
    relTag = tag;
    causeReq = req;
    @(negedge clk);
    causeReq = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R11: reset state, explicit
    cmp("R11", "sysRstN in reset", sysRstN, 0);
    cmp("R11", "causeLatched in reset", causeLatched, 0);
    cmp("R11", "runEnable in reset", runEnable, 0);
    rstN = 1'b1;
    idle(4);
    cmp("R11", "clkReady before request", clkReady, 0);
    cmp("R11", "monitorEnable before request", monitorEnable, 0);
    // R1 R4: power-on, short startup, crystal with PLL
    regulatorOn = 1; clkClass = 2'b11;
    request(8'h01, "R1_R4");
    clkClass = 2'b00;  // change after sampling must not matter
    idle(80);
    // R1 R4: power-on, long startup, plain clock
    regulatorOn = 0;
    request(8'h01, "R1_R4");
    idle(80);
    // R2: brown-out, crystal
    regulatorOn = 1; clkClass = 2'b10;
    request(8'h02, "R2");
    idle(80);
    // R3: watchdog, PLL, boot keeps current source
    clkClass = 2'b01;
    request(8'h08, "R3");
    idle(60);
    // R3: software with switching disabled
    switchEnable = 0; clkClass = 2'b11;
    request(8'h10, "R3");
    idle(60);
    switchEnable = 1;
    // R8: brown-out wins over pin and trap
    clkClass = 2'b10;
    request(8'hA6, "R2");
    idle(80);
    // R8: illegal opcode wins over uninitialized register
    request(8'h60, "R3");
    idle(60);
    // R10: restart mid-sequence with a trap conflict
    regulatorOn = 0; clkClass = 2'b11;
    request(8'h01, "R10");
    idle(12);
    request(8'h80, "R10");
    idle(60);
    // R10: pin request after full release, class changes
    clkClass = 2'b00;
    request(8'h04, "R10");
    idle(30);
    cmp("R6", "runEnable final", runEnable, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule